// File: doc/BRIEF.md
# PPS-Gated Microsecond Offset Counter

This block reports how many microseconds have passed since the last rising edge of a pulse-per-second input. A host read can then be tied to the true second. The count advances once for each cycle in which a one-microsecond tick enable is high. It returns to zero whenever a rising edge of the PPS input is seen. The PPS input is asynchronous, so the block passes it through a flop synchroniser and turns its rising edge into a single-cycle restart pulse inside the clock domain.

The count is 16 bits wide, so it rolls over after 65535 µs (about 65 ms). A sticky wrap flag records that a rollover has happened since the last restart. A host that reads 100 therefore knows whether that means 100 µs or 65636 µs past the second, and can reject a reading that is stale.

A snapshot strobe copies the live count and the wrap flag into holding registers in one cycle. The host then reads a pair of values that belong together.

Top module: `pps_offset_ctr`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it rises, count_o, wrap_o, snap_count_o and snap_wrap_o are all zero.
- R2: In a cycle with no restart, a high us_tick_i increments count_o by one (modulo 2^16) at the next clock edge. A low us_tick_i leaves count_o unchanged.
- R3: After pps_i rises, count_o reads zero following the third rising clock edge at which pps_i is sampled high. A pps_i that stays high without a new rising edge causes no further restart.
- R4: When count_o is 65535 and a tick arrives with no restart, count_o becomes 0 and wrap_o becomes 1. wrap_o then stays at 1 through further ticks and further rollovers.
- R5: wrap_o returns to 0 only on a PPS restart.
- R6: When snap_i is high at a clock edge, snap_count_o and snap_wrap_o take the values that count_o and wrap_o had just before that edge. When snap_i is low, the two snapshot outputs hold their values.
- R7: If a PPS restart and a microsecond tick fall in the same cycle, the restart wins and count_o becomes 0, not 1.
- R8: A snapshot taken in the same cycle as a restart captures the count and the wrap flag from before the restart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| us_tick_i | input | 1 | One-cycle enable, one per microsecond |
| pps_i | input | 1 | Asynchronous pulse-per-second input |
| snap_i | input | 1 | Snapshot strobe |
| count_o | output | 16 | Live microseconds since the last PPS edge |
| wrap_o | output | 1 | Sticky flag: the live count has wrapped since the last edge |
| snap_count_o | output | 16 | Held count from the last snapshot |
| snap_wrap_o | output | 1 | Held wrap flag from the last snapshot |

## Verification
The PPS restart can fall in the same cycle as a microsecond tick, and also in the same cycle as a snapshot strobe. To provoke both, the bench holds the tick high continuously, raises pps_i, and drives snap_i in exactly the cycle where the synchronised edge becomes a restart. It then checks two results: the live count goes to zero rather than one, and the snapshot holds the non-zero count from before the restart. A behavioural reference model judges every cycle. One long run takes the count past 65535 to check that the wrap flag stays set and is then cleared by the next edge.

// File: rtl/pps_offset_pkg.sv
package pps_offset_pkg;
  localparam int unsigned CNT_W_DEF  = 16;
  localparam int unsigned SYNC_N_DEF = 2;

  function automatic int unsigned cnt_max(input int unsigned w);
    return (32'd1 << w) - 32'd1;
  endfunction
endpackage

// File: rtl/pps_sync_edge.sv
module pps_sync_edge #(
  parameter int unsigned SYNC_N = pps_offset_pkg::SYNC_N_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pps_i,
  output logic rise_o
);
  logic [SYNC_N-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q[0] <= 1'b0;
    else         sync_q[0] <= pps_i;
  end

  for (genvar g = 1; g < SYNC_N; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[g] <= 1'b0;
      else         sync_q[g] <= sync_q[g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= sync_q[SYNC_N-1];
  end

  assign rise_o = sync_q[SYNC_N-1] & ~last_q;
endmodule

// File: rtl/us_elapsed_ctr.sv
module us_elapsed_ctr #(
  parameter int unsigned CNT_W = pps_offset_pkg::CNT_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] count_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] CntTop = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             wrap_q;

  // restart outranks tick
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      wrap_q <= 1'b0;
    end else if (restart_i) begin
      cnt_q  <= '0;
      wrap_q <= 1'b0;
    end else if (tick_i) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CntTop) wrap_q <= 1'b1;
    end
  end

  assign count_o = cnt_q;
  assign wrap_o  = wrap_q;
endmodule

// File: rtl/offs_snap_hold.sv
module offs_snap_hold #(
  parameter int unsigned CNT_W = pps_offset_pkg::CNT_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             snap_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             wrap_i,
  output logic [CNT_W-1:0] count_o,
  output logic             wrap_o
);
  logic [CNT_W:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hold_q <= '0;
    else if (snap_i) hold_q <= {wrap_i, count_i};
  end

  assign count_o = hold_q[CNT_W-1:0];
  assign wrap_o  = hold_q[CNT_W];
endmodule

// File: rtl/pps_offset_ctr.sv
module pps_offset_ctr #(
  parameter int unsigned CNT_W  = pps_offset_pkg::CNT_W_DEF,
  parameter int unsigned SYNC_N = pps_offset_pkg::SYNC_N_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             us_tick_i,
  input  logic             pps_i,
  input  logic             snap_i,
  output logic [CNT_W-1:0] count_o,
  output logic             wrap_o,
  output logic [CNT_W-1:0] snap_count_o,
  output logic             snap_wrap_o
);
  logic restart;

  pps_sync_edge #(.SYNC_N(SYNC_N)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pps_i  (pps_i),
    .rise_o (restart)
  );

  us_elapsed_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .tick_i    (us_tick_i),
    .count_o   (count_o),
    .wrap_o    (wrap_o)
  );

  offs_snap_hold #(.CNT_W(CNT_W)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .snap_i  (snap_i),
    .count_i (count_o),
    .wrap_i  (wrap_o),
    .count_o (snap_count_o),
    .wrap_o  (snap_wrap_o)
  );
endmodule

// File: rtl/pps_offset_ctr_chk.sv
module pps_offset_ctr_chk #(
  parameter int unsigned CNT_W = pps_offset_pkg::CNT_W_DEF
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             us_tick_i,
  input logic             snap_i,
  input logic             restart_i,
  input logic [CNT_W-1:0] count_i,
  input logic             wrap_i,
  input logic [CNT_W-1:0] snap_count_i,
  input logic             snap_wrap_i
);
  localparam logic [CNT_W-1:0] CntTop = {CNT_W{1'b1}};

  // R2
  tick_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!restart_i && us_tick_i) |=> (count_i == CNT_W'($past(count_i) + 1'b1)));

  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!restart_i && !us_tick_i) |=> $stable(count_i));

  // R3
  restart_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !restart_i);

  // R7
  restart_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (count_i == '0 && !wrap_i));

  // R4
  wrap_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!restart_i && us_tick_i && count_i == CntTop) |=> wrap_i);

  // R5
  wrap_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_i && !restart_i) |=> wrap_i);

  // R6
  snap_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snap_i |=> (snap_count_i == $past(count_i) && snap_wrap_i == $past(wrap_i)));

  // R6
  snap_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snap_i |=> ($stable(snap_count_i) && $stable(snap_wrap_i)));
endmodule

bind pps_offset_ctr pps_offset_ctr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .us_tick_i    (us_tick_i),
  .snap_i       (snap_i),
  .restart_i    (restart),
  .count_i      (count_o),
  .wrap_i       (wrap_o),
  .snap_count_i (snap_count_o),
  .snap_wrap_i  (snap_wrap_o)
);

// File: tb/tb_pps_offset_ctr.sv
module tb_pps_offset_ctr;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam int TOP = 65535;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, pps = 1'b0, snap = 1'b0;
  logic [W-1:0] count_w, hcount_w;
  logic wrap_w, hwrap_w;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // reference model state
  int m_cnt = 0, m_hcnt = 0;
  bit m_wrap = 0, m_hwrap = 0;
  bit pq[$] = '{0, 0, 0};

  always #(CLK_PERIOD/2) clk = ~clk;

  pps_offset_ctr dut (
    .clk_i(clk), .rst_ni(rst_n), .us_tick_i(tick), .pps_i(pps), .snap_i(snap),
    .count_o(count_w), .wrap_o(wrap_w),
    .snap_count_o(hcount_w), .snap_wrap_o(hwrap_w)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_wrap = 0; m_hcnt = 0; m_hwrap = 0;
      pq = '{0, 0, 0};
    end else begin
      bit rise;
      rise = pq[1] && !pq[2];
      if (snap) begin m_hcnt = m_cnt; m_hwrap = m_wrap; end // R8: pre-restart values
      if (rise) begin m_cnt = 0; m_wrap = 0; end            // R7: restart wins
      else if (tick) begin
        if (m_cnt == TOP) begin m_cnt = 0; m_wrap = 1; end
        else m_cnt = m_cnt + 1;
      end
      pq = '{pps, pq[0], pq[1]};
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against model
  always @(negedge clk) if (rst_n && !done) begin
    chk(int'(count_w) == m_cnt, "R2/R3 count", int'(count_w), m_cnt);
    chk(wrap_w == m_wrap, "R4/R5 wrap", int'(wrap_w), int'(m_wrap));
    chk(int'(hcount_w) == m_hcnt, "R6 snap_count", int'(hcount_w), m_hcnt);
    chk(hwrap_w == m_hwrap, "R6 snap_wrap", int'(hwrap_w), int'(m_hwrap));
  end

  task automatic drive(input bit t, input bit p, input bit s);
    @(negedge clk);
    tick = t; pps = p; snap = s;
  endtask

  task automatic summary();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(count_w == 0 && !wrap_w && hcount_w == 0 && !hwrap_w, "R1 reset", int'(count_w), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(count_w == 0 && !wrap_w, "R1 after release", int'(count_w), 0);

    // R2/R3: sparse ticks, long PPS highs, periodic snapshots
    for (int i = 0; i < 300; i++)
      drive(i % 3 == 0, (i >= 50 && i < 90) || (i >= 180 && i < 185), i % 17 == 0);

    // R3: exact latency of restart, pps held high afterwards
    for (int i = 0; i < 20; i++) drive(1'b1, 1'b0, 1'b0);
    drive(1'b1, 1'b1, 1'b0);
    @(negedge clk); @(negedge clk);
    chk(count_w != 0, "R3 before third edge", int'(count_w), 1);
    @(negedge clk);
    chk(count_w == 0, "R3 restart latency", int'(count_w), 0);
    @(negedge clk);
    chk(count_w == 1, "R3 no re-restart on high level", int'(count_w), 1);

    // R7/R8: restart coincides with tick and snapshot
    drive(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 30; i++) drive(1'b1, 1'b0, 1'b0);
    drive(1'b1, 1'b1, 1'b0);
    @(negedge clk); @(negedge clk);
    snap = 1'b1;
    @(negedge clk);
    snap = 1'b0;
    chk(count_w == 0, "R7 restart beats tick", int'(count_w), 0);
    chk(hcount_w > 30, "R8 snapshot pre-restart", int'(hcount_w), 31);

    // R4: roll over, stay sticky across a second wrap
    drive(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 2 * (TOP + 1) + 10; i++) drive(1'b1, 1'b0, i == TOP + 5);
    chk(wrap_w == 1'b1, "R4 wrap sticky", int'(wrap_w), 1);
    chk(hwrap_w == 1'b1, "R6 snapshot of wrap", int'(hwrap_w), 1);

    // R5: only PPS clears the flag
    drive(1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 5; i++) drive(1'b0, 1'b1, 1'b0);
    chk(wrap_w == 1'b0, "R5 wrap cleared by pps", int'(wrap_w), 0);

    // mixed stimulus
    for (int i = 0; i < 3000; i++)
      drive(($urandom % 4) != 0, (i % 400) >= 200, ($urandom % 13) == 0);

    @(negedge clk);
    summary();
  end
endmodule